// File: doc/BRIEF.md
# TDM Timeslot Channel Router

This block connects a 32-slot time-division serial frame (8 bits per slot, MSB first) to a local terminal. The first four slots have fixed roles. Slot 0 carries two bits of the 16 kb/s signalling channel. Slot 1 carries a transceiver control/status byte. Slots 2 and 3 are the two 64 kb/s voice channels. Every other slot is left released on the line. A single system clock runs the block. A one-cycle `bit_en` strobe marks each bit boundary, and `frm_sync`, raised together with `bit_en`, starts bit 0 of slot 0.

A small register port holds four slot-enable bits, the control byte to transmit, and two pin-level loop-back switches. Reading the control-byte address returns the last control byte received. The voice path exchanges a parallel byte with the audio side. The signalling and control paths report each received field with a one-cycle strobe.

Each slot that is not in use has its own idle behaviour. An unused voice slot drives zeros, while an unused control or signalling slot releases the line.

Top module: `tsr_router`

## Requirements
- R1: After reset the slot enables and both loop-back bits are 0 and the control transmit byte is 0xFF. `ser_oe` stays low until the first `frm_sync` arrives with `bit_en`.
- R2: The `bit_en` edge that carries `frm_sync` starts bit 0 of slot 0. Each later `bit_en` advances one bit, MSB first, through 32 slots. `ser_oe` is low for all of slots 4 to 31 and changes only on `bit_en` edges.
- R3: Transmit and receive PCM use slot 2 when enable bit 2 is set, and slot 3 when only enable bit 3 is set. When both are set, slot 2 wins. When neither is set, no PCM is received.
- R4: Slots 2 and 3 are always driven (`ser_oe` high for all 8 bits). A voice slot that does not carry PCM sends eight zeros.
- R5: With enable bit 1 high, slot 1 sends the control transmit byte. With it low, `ser_oe` is low for slot 1.
- R6: The byte received in slot 1 is always captured, whatever enable bit 1 holds. It is readable at address 1, and `c_rx_vld` pulses once per frame.
- R7: Signalling uses the two MSB positions of slot 0. With enable bit 0 high, slot 0 is driven with `d_tx` followed by six ones; with it low, slot 0 is released. After the second bit of slot 0, `d_rx` is updated and `d_rx_vld` pulses for one cycle.
- R8: `pcm_tx` is taken when the selected voice slot begins. After its last bit, `pcm_rx` holds the received byte and `pcm_rx_vld` pulses for exactly one cycle. The three receive strobes never coincide.
- R9: Loop-back bit 6 (address 3) drives `ser_in` straight onto `ser_out`, while `ser_oe` still follows the slot enables.
- R10: Loop-back bit 5 (address 3) makes the receive path sample the block's own line instead of `ser_in`. A released slot reads as all ones.
- R11: Address 2 holds the enables in bits 3:0 and address 3 holds the loop-back bits 6 and 5. Reserved bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| frm_sync | input | 1 | Frame start, valid with bit_en |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Transmit driver enable |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address (1 ctl byte, 2 enables, 3 loop-back) |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| pcm_tx | input | 8 | Voice byte to send |
| pcm_rx | output | 8 | Voice byte received |
| pcm_rx_vld | output | 1 | pcm_rx update strobe |
| d_tx | input | 2 | Signalling bits to send |
| d_rx | output | 2 | Signalling bits received |
| d_rx_vld | output | 1 | d_rx update strobe |
| c_rx_vld | output | 1 | Control byte capture strobe |

## Verification
The hardest condition to reach is the set of line states hidden behind the loop-back switches. With loop-back to input, a released slot must come back as all ones, and the received control byte must reflect that even though the control slot is disabled. The bench reaches these states by driving whole frames that combine specific enable patterns with each loop-back bit, then reading the captured control byte back through the register port. Whole frames with both voice enables set check the slot-2 priority, while slot 3 is seen to carry zeros.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int unsigned TSR_SLOTS = 32;
    localparam int unsigned TSR_BITS  = 8;
    localparam int unsigned TSR_DBITS = 2;
    localparam int unsigned SLOT_IW   = $clog2(TSR_SLOTS);
    localparam int unsigned BIT_IW    = $clog2(TSR_BITS);
    localparam int unsigned REG_AW    = 2;
    localparam int unsigned N_EN      = 4;

    localparam int unsigned SLOT_D  = 0;
    localparam int unsigned SLOT_C  = 1;
    localparam int unsigned SLOT_B1 = 2;
    localparam int unsigned SLOT_B2 = 3;

    localparam int unsigned LB_IO_BIT = 6;
    localparam int unsigned LB_OI_BIT = 5;

    typedef logic [TSR_BITS-1:0] byte_t;

    typedef struct packed {
        logic [SLOT_IW-1:0] slot;
        logic [BIT_IW-1:0]  bitn;
    } pos_t;

    typedef enum logic [REG_AW-1:0] {
        RA_NONE = 2'd0,
        RA_CTL  = 2'd1,
        RA_EN   = 2'd2,
        RA_LOOP = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [N_EN-1:0] ch_en;
        logic            lb_in2out;
        logic            lb_out2in;
        byte_t           c_tx;
    } ctrl_t;

    // Voice slot selection: the lower voice slot takes priority.
    function automatic logic is_pcm_slot(input logic [SLOT_IW-1:0] slot,
                                         input logic [N_EN-1:0] en);
        return (slot == SLOT_IW'(SLOT_B1) && en[SLOT_B1]) ||
               (slot == SLOT_IW'(SLOT_B2) && en[SLOT_B2] && !en[SLOT_B1]);
    endfunction
endpackage

// File: rtl/tsr_regs.sv
module tsr_regs
    import tsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  byte_t             wdata,
    input  logic [REG_AW-1:0] raddr,
    input  byte_t             c_rx,
    output ctrl_t             ctrl,
    output byte_t             rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{ch_en: '0, lb_in2out: 1'b0, lb_out2in: 1'b0, c_tx: '1};
        end else if (we) begin
            case (reg_addr_e'(waddr))
                RA_CTL:  ctrl.c_tx <= wdata;
                RA_EN:   ctrl.ch_en <= wdata[N_EN-1:0];
                RA_LOOP: begin
                    ctrl.lb_in2out <= wdata[LB_IO_BIT];
                    ctrl.lb_out2in <= wdata[LB_OI_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(raddr))
            RA_CTL:  rdata = c_rx;
            RA_EN:   rdata[N_EN-1:0] = ctrl.ch_en;
            RA_LOOP: begin
                rdata[LB_IO_BIT] = ctrl.lb_in2out;
                rdata[LB_OI_BIT] = ctrl.lb_out2in;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsr_timing.sv
module tsr_timing
    import tsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic frm_sync,
    output pos_t cur,
    output logic cur_vld,
    output pos_t nxt,
    output logic nxt_vld
);
    always_comb begin
        nxt     = cur;
        nxt_vld = cur_vld;
        if (frm_sync) begin
            nxt     = '0;
            nxt_vld = 1'b1;
        end else if (cur_vld) begin
            if (cur.bitn == BIT_IW'(TSR_BITS - 1)) begin
                nxt.bitn = '0;
                nxt.slot = (cur.slot == SLOT_IW'(TSR_SLOTS - 1)) ? '0
                                                                 : cur.slot + SLOT_IW'(1);
            end else begin
                nxt.bitn = cur.bitn + BIT_IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            cur_vld <= 1'b0;
        end else if (bit_en) begin
            cur     <= nxt;
            cur_vld <= nxt_vld;
        end
    end
endmodule

// File: rtl/tsr_tx.sv
module tsr_tx
    import tsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  pos_t                 nxt,
    input  logic                 nxt_vld,
    input  ctrl_t                ctrl,
    input  byte_t                pcm_tx,
    input  logic [TSR_DBITS-1:0] d_tx,
    output logic                 tx_bit,
    output logic                 tx_oe
);
    byte_t sh;
    byte_t ld_byte;
    logic  ld_oe;

    always_comb begin
        ld_byte = '1;
        ld_oe   = 1'b0;
        if (nxt.slot == SLOT_IW'(SLOT_D)) begin
            ld_byte = {d_tx, {(TSR_BITS - TSR_DBITS){1'b1}}};
            ld_oe   = ctrl.ch_en[SLOT_D];
        end else if (nxt.slot == SLOT_IW'(SLOT_C)) begin
            ld_byte = ctrl.c_tx;
            ld_oe   = ctrl.ch_en[SLOT_C];
        end else if (nxt.slot == SLOT_IW'(SLOT_B1) || nxt.slot == SLOT_IW'(SLOT_B2)) begin
            ld_byte = is_pcm_slot(nxt.slot, ctrl.ch_en) ? pcm_tx : '0;
            ld_oe   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            tx_bit <= 1'b1;
            tx_oe  <= 1'b0;
        end else if (adv) begin
            if (!nxt_vld) begin
                tx_bit <= 1'b1;
                tx_oe  <= 1'b0;
            end else if (nxt.bitn == '0) begin
                tx_bit <= ld_byte[TSR_BITS-1];
                sh     <= {ld_byte[TSR_BITS-2:0], 1'b1};
                tx_oe  <= ld_oe;
            end else begin
                tx_bit <= sh[TSR_BITS-1];
                sh     <= {sh[TSR_BITS-2:0], 1'b1};
            end
        end
    end
endmodule

// File: rtl/tsr_rx.sv
module tsr_rx
    import tsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  pos_t                 cur,
    input  logic                 cur_vld,
    input  logic                 rbit,
    input  logic [N_EN-1:0]      ch_en,
    output byte_t                pcm_rx,
    output logic                 pcm_vld,
    output byte_t                c_rx,
    output logic                 c_vld,
    output logic [TSR_DBITS-1:0] d_rx,
    output logic                 d_vld
);
    byte_t sh;
    byte_t sh_nxt;

    assign sh_nxt = {sh[TSR_BITS-2:0], rbit};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            pcm_rx  <= '0;
            pcm_vld <= 1'b0;
            c_rx    <= '0;
            c_vld   <= 1'b0;
            d_rx    <= '0;
            d_vld   <= 1'b0;
        end else begin
            pcm_vld <= 1'b0;
            c_vld   <= 1'b0;
            d_vld   <= 1'b0;
            if (adv && cur_vld) begin
                sh <= sh_nxt;
                if (cur.bitn == BIT_IW'(TSR_BITS - 1)) begin
                    if (cur.slot == SLOT_IW'(SLOT_C)) begin
                        c_rx  <= sh_nxt;
                        c_vld <= 1'b1;
                    end
                    if (is_pcm_slot(cur.slot, ch_en)) begin
                        pcm_rx  <= sh_nxt;
                        pcm_vld <= 1'b1;
                    end
                end
                if (cur.slot == SLOT_IW'(SLOT_D) && cur.bitn == BIT_IW'(TSR_DBITS - 1)) begin
                    d_rx  <= sh_nxt[TSR_DBITS-1:0];
                    d_vld <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tsr_router.sv
module tsr_router
    import tsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        frm_sync,
    input  logic        ser_in,
    output logic        ser_out,
    output logic        ser_oe,
    input  logic        reg_we,
    input  logic [1:0]  reg_waddr,
    input  logic [7:0]  reg_wdata,
    input  logic [1:0]  reg_raddr,
    output logic [7:0]  reg_rdata,
    input  logic [7:0]  pcm_tx,
    output logic [7:0]  pcm_rx,
    output logic        pcm_rx_vld,
    input  logic [1:0]  d_tx,
    output logic [1:0]  d_rx,
    output logic        d_rx_vld,
    output logic        c_rx_vld
);
    ctrl_t           ctrl;
    byte_t           c_rx;
    pos_t            cur, nxt;
    logic            cur_vld, nxt_vld;
    logic            tx_bit, tx_oe;
    logic            line_bit, rx_bit;
    logic [N_EN-1:0] ch_en_q;

    assign ch_en_q = ctrl.ch_en;

    tsr_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .c_rx(c_rx), .ctrl(ctrl), .rdata(reg_rdata)
    );

    tsr_timing u_timing (
        .clk(clk), .rst(rst), .bit_en(bit_en), .frm_sync(frm_sync),
        .cur(cur), .cur_vld(cur_vld), .nxt(nxt), .nxt_vld(nxt_vld)
    );

    tsr_tx u_tx (
        .clk(clk), .rst(rst), .adv(bit_en), .nxt(nxt), .nxt_vld(nxt_vld),
        .ctrl(ctrl), .pcm_tx(pcm_tx), .d_tx(d_tx), .tx_bit(tx_bit), .tx_oe(tx_oe)
    );

    // Pin-level loop-back muxes; a released line reads back as one.
    assign line_bit = tx_oe ? tx_bit : 1'b1;
    assign rx_bit   = ctrl.lb_out2in ? line_bit : ser_in;
    assign ser_out  = ctrl.lb_in2out ? ser_in : tx_bit;
    assign ser_oe   = tx_oe;

    tsr_rx u_rx (
        .clk(clk), .rst(rst), .adv(bit_en), .cur(cur), .cur_vld(cur_vld),
        .rbit(rx_bit), .ch_en(ctrl.ch_en), .pcm_rx(pcm_rx), .pcm_vld(pcm_rx_vld),
        .c_rx(c_rx), .c_vld(c_rx_vld), .d_rx(d_rx), .d_vld(d_rx_vld)
    );
endmodule

// File: rtl/tsr_router_chk.sv
module tsr_router_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       ser_oe,
    input logic       pcm_rx_vld,
    input logic       c_rx_vld,
    input logic       d_rx_vld,
    input logic [3:0] ch_en
);
    p_oe_moves_on_bit_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(ser_oe));

    p_no_pcm_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(ch_en[3:2]) == 2'b00) |-> !pcm_rx_vld);

    p_c_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        c_rx_vld |=> !c_rx_vld);

    p_d_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        d_rx_vld |=> !d_rx_vld);

    p_pcm_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        pcm_rx_vld |=> !pcm_rx_vld);

    p_strobes_apart_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pcm_rx_vld, c_rx_vld, d_rx_vld}));
endmodule

bind tsr_router tsr_router_chk chk_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_oe(ser_oe),
    .pcm_rx_vld(pcm_rx_vld), .c_rx_vld(c_rx_vld), .d_rx_vld(d_rx_vld),
    .ch_en(ch_en_q)
);

// File: tb/tsr_router_tb.sv
`timescale 1ns/1ps
module tsr_router_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0, frm_sync = 1'b0, ser_in = 1'b0;
    logic       ser_out, ser_oe;
    logic       reg_we = 1'b0;
    logic [1:0] reg_waddr = '0, reg_raddr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [7:0] pcm_tx = '0, pcm_rx;
    logic       pcm_rx_vld, d_rx_vld, c_rx_vld;
    logic [1:0] d_tx = '0, d_rx;

    always #2.5 clk = ~clk;

    tsr_router dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .frm_sync(frm_sync), .ser_in(ser_in),
        .ser_out(ser_out), .ser_oe(ser_oe), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .pcm_tx(pcm_tx), .pcm_rx(pcm_rx), .pcm_rx_vld(pcm_rx_vld), .d_tx(d_tx),
        .d_rx(d_rx), .d_rx_vld(d_rx_vld), .c_rx_vld(c_rx_vld)
    );

    typedef struct packed {
        logic [3:0]  en;
        logic        io;
        logic        oi;
        logic [7:0]  ctx;
        logic [7:0]  pcm;
        logic [1:0]  d;
        logic [31:0] rx;
        logic [3:0]  e_oe;
        logic [31:0] e_tx;
        logic [7:0]  e_pcm;
        logic        e_pv;
        logic [7:0]  e_c;
        logic [1:0]  e_d;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{en:4'b0000, io:1'b0, oi:1'b0, ctx:8'hA5, pcm:8'h3C, d:2'b10, rx:32'h005A9669,
          e_oe:4'b1100, e_tx:32'h00000000, e_pcm:8'h00, e_pv:1'b0, e_c:8'h5A, e_d:2'b00},
        '{en:4'b0100, io:1'b0, oi:1'b0, ctx:8'hA5, pcm:8'h3C, d:2'b10, rx:32'h800F9669,
          e_oe:4'b1100, e_tx:32'h00003C00, e_pcm:8'h96, e_pv:1'b1, e_c:8'h0F, e_d:2'b10},
        '{en:4'b1000, io:1'b0, oi:1'b0, ctx:8'hA5, pcm:8'hC3, d:2'b10, rx:32'h40F09669,
          e_oe:4'b1100, e_tx:32'h000000C3, e_pcm:8'h69, e_pv:1'b1, e_c:8'hF0, e_d:2'b01},
        '{en:4'b1111, io:1'b0, oi:1'b0, ctx:8'hA5, pcm:8'hE7, d:2'b01, rx:32'hC033817E,
          e_oe:4'b1111, e_tx:32'h7FA5E700, e_pcm:8'h81, e_pv:1'b1, e_c:8'h33, e_d:2'b11},
        '{en:4'b1110, io:1'b0, oi:1'b1, ctx:8'hC9, pcm:8'h5A, d:2'b11, rx:32'h00000000,
          e_oe:4'b1110, e_tx:32'h00C95A00, e_pcm:8'h5A, e_pv:1'b1, e_c:8'hC9, e_d:2'b11},
        '{en:4'b0000, io:1'b0, oi:1'b1, ctx:8'hC9, pcm:8'h5A, d:2'b00, rx:32'h00000000,
          e_oe:4'b1100, e_tx:32'h00000000, e_pcm:8'h00, e_pv:1'b0, e_c:8'hFF, e_d:2'b11},
        '{en:4'b0110, io:1'b1, oi:1'b0, ctx:8'hC9, pcm:8'h5A, d:2'b00, rx:32'h12345678,
          e_oe:4'b1110, e_tx:32'h00345678, e_pcm:8'h56, e_pv:1'b1, e_c:8'h34, e_d:2'b00}
    };

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [39:0] cap_oe, cap_out;
    int   pv_cnt, cv_cnt, dv_cnt;
    logic [7:0] got_pcm;
    logic [1:0] got_d;

    always @(negedge clk) begin
        if (pcm_rx_vld) begin pv_cnt++; got_pcm = pcm_rx; end
        if (c_rx_vld)   cv_cnt++;
        if (d_rx_vld)   begin dv_cnt++; got_d = d_rx; end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_raddr = a;
        #1 v = reg_rdata;
    endtask

    // Run slots 0..4 of one frame, 4 clocks per bit, capturing the line.
    task automatic run_frame(input logic [31:0] rx);
        pv_cnt = 0; cv_cnt = 0; dv_cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            bit_en = 1'b1; frm_sync = (k == 0);
            @(negedge clk);
            bit_en = 1'b0; frm_sync = 1'b0;
            ser_in = (k < 32) ? rx[31 - k] : 1'b0;
            #1;
            cap_oe[k]  = ser_oe;
            cap_out[k] = ser_out;
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] slot_byte(input logic [39:0] c, input int s);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7 - i] = c[s * 8 + i];
        return b;
    endfunction

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state
        rd(2'd2, rv); check("R1 enables after reset", 32'(rv), 32'h0);
        rd(2'd3, rv); check("R1 loop-back after reset", 32'(rv), 32'h0);
        check("R1 line released after reset", 32'(ser_oe), 32'h0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); bit_en = 1'b1;
            @(negedge clk); bit_en = 1'b0;
        end
        #1 check("R1 no drive before frame sync", 32'(ser_oe), 32'h0);
        // Register map and reserved bits
        wr(2'd2, 8'hFF); rd(2'd2, rv); check("R11 enable reserved bits", 32'(rv), 32'h0F);
        wr(2'd3, 8'hFF); rd(2'd3, rv); check("R11 loop-back reserved bits", 32'(rv), 32'h60);
        wr(2'd3, 8'h00);
        // Reset value of the control transmit byte, seen on slot 1
        wr(2'd2, 8'h02);
        run_frame(32'h0);
        check("R1 control byte reset value", 32'(slot_byte(cap_out, 1)), 32'hFF);
        check("R5 slot 1 driven", 32'(slot_byte(cap_oe, 1)), 32'hFF);

        // Table of vectors
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic [7:0] exp_oe_b;
            logic [7:0] exp_tx_b;
            t = VECS[v];
            wr(2'd1, t.ctx);
            wr(2'd2, {4'b0, t.en});
            wr(2'd3, {1'b0, t.io, t.oi, 5'b0});
            pcm_tx = t.pcm; d_tx = t.d;
            run_frame(t.rx);
            for (int s = 0; s < 5; s++) begin
                exp_oe_b = (s < 4 && t.e_oe[s]) ? 8'hFF : 8'h00;
                case (s)
                    0: check("R7 slot 0 enable", 32'(slot_byte(cap_oe, s)), 32'(exp_oe_b));
                    1: check("R5 slot 1 enable", 32'(slot_byte(cap_oe, s)), 32'(exp_oe_b));
                    4: check("R2 slot 4 released", 32'(slot_byte(cap_oe, s)), 32'(exp_oe_b));
                    default: check("R4 voice slot driven", 32'(slot_byte(cap_oe, s)), 32'(exp_oe_b));
                endcase
                if (s < 4 && t.e_oe[s]) begin
                    exp_tx_b = t.e_tx[31 - s * 8 -: 8];
                    if (t.io)
                        check("R9 input looped to output", 32'(slot_byte(cap_out, s)), 32'(exp_tx_b));
                    else
                        check("R3 R4 R5 R7 slot data", 32'(slot_byte(cap_out, s)), 32'(exp_tx_b));
                end
            end
            check("R8 pcm strobe count", 32'(pv_cnt), 32'(t.e_pv));
            if (t.e_pv)
                check(t.oi ? "R10 pcm looped back" : "R3 R8 pcm received", 32'(got_pcm), 32'(t.e_pcm));
            check("R6 control strobe count", 32'(cv_cnt), 32'h1);
            rd(2'd1, rv);
            check(t.oi ? "R10 control byte looped" : "R6 control byte captured", 32'(rv), 32'(t.e_c));
            check("R7 signalling strobe count", 32'(dv_cnt), 32'h1);
            check("R7 signalling bits received", 32'(got_d), 32'(t.e_d));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule